// File: doc/BRIEF.md
# Soft Interrupt Level Arbiter

This block sits beside a CPU core and works out which interrupt level the core should take next. It keeps a 32-bit software-interrupt register that privileged code changes through a small register-op port. Each op carries a kind and two source operands, and the value written is always the bitwise XOR of the two sources. Three timer event inputs set the register's bit 0, which acts as the timer interrupt bit.

Every cycle the block forms a 16-bit request vector. It ORs the registered external level lines, the software bits 15..1, and the timer bit moved onto level 14. A scan then finds the highest active level between 15 and 1 and latches a trap-type code made of an external-interrupt base and that level. A one-cycle pulse marks each change of the latched code. When all requests go away, a second pulse marks the withdrawal. The core shares the pending-code register through a load port. A code the core loads whose upper bits are not the external base is left alone by the arbiter.

Top module: `softint_level_arbiter`

## Requirements
- R1: A privileged op of kind 1 (set) ORs the low 32 bits of `op_src_a ^ op_src_b` into the software register at the clock edge.
- R2: A privileged op of kind 2 (clear) ANDs the software register with the inverse of the low 32 bits of `op_src_a ^ op_src_b`.
- R3: A privileged op of kind 3 (write) replaces the software register with the low 32 bits of `op_src_a ^ op_src_b`.
- R4: An op presented with `op_priv` low drives `op_illegal` high in the same cycle, returns zero on `rd_data`, and does not change the software register.
- R5: A privileged op of kind 0 (read) returns the software register, zero-extended to 64 bits, on `rd_data` in the same cycle. Otherwise `rd_data` is zero.
- R6: Any of `tick_hit`, `stick_hit` or `htick_hit` sets software bit 0 at the edge. This wins over a clear or write of bit 0 in the same cycle.
- R7: The request vector is the registered lines, OR software bits 15..1, OR software bit 0 placed at level 14. Level 0 never selects a code.
- R8: Lines are registered at an edge, and the pending code follows at the next edge. When the pending code is zero or external (bits 8..4 equal 0x4) and some level 15..1 is requested, `pend_code` becomes 0x040 | highest level.
- R9: `irq_set` is high for exactly the cycle after an edge at which the arbiter changed `pend_code` to a new external code, and at no other time.
- R10: When the request vector is all zero and the pending code is external, `pend_code` is cleared to 0 and `irq_drop` pulses for one cycle.
- R11: `trap_load` writes `trap_code` into `pend_code` with priority and no pulse. A nonzero code whose bits 8..4 are not 0x4 is neither replaced nor cleared by the arbiter.
- R12: `halted` is set by `sleep_req`. It is cleared when any line of `lvl_in` rises from its registered value, and the clear wins.
- R13: Reset clears the software register, the registered lines, `pend_code`, both pulses and `halted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Register op presented this cycle |
| op_kind | input | 2 | 0 read, 1 set, 2 clear, 3 write |
| op_priv | input | 1 | Core is in supervisor mode |
| op_src_a | input | 64 | First source operand |
| op_src_b | input | 64 | Second source operand |
| rd_data | output | 64 | Read data, zero-extended register |
| op_illegal | output | 1 | Op refused for lack of privilege |
| lvl_in | input | 16 | External interrupt level lines |
| tick_hit | input | 1 | Tick compare event |
| stick_hit | input | 1 | System tick compare event |
| htick_hit | input | 1 | Hyper tick compare event |
| sleep_req | input | 1 | Core enters halted state |
| trap_load | input | 1 | Core overwrites the pending code |
| trap_code | input | 9 | Code written by the core |
| pend_code | output | 9 | Latched pending trap-type code |
| irq_set | output | 1 | Pulse: new external code latched |
| irq_drop | output | 1 | Pulse: external request withdrawn |
| halted | output | 1 | Core halted flag |

## Verification
The main function is driven first with single directed levels. These separate the timer-to-level-14 mapping from a plain line at level 14, and show that level 0 alone leaves the code at zero. A rising sequence of levels then checks that only real code changes pulse. Long random runs use sparse line patterns, random set, clear and write ops with non-trivial XOR operand pairs, timer hits, and occasional core loads of external and non-external codes. These runs tell the blocking rule apart from the replace and clear rules. A reference model in the bench checks every cycle.

// File: rtl/softint_pkg.sv
package softint_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_WRITE = 2'd3
  } sop_e;

endpackage

// File: rtl/softint_reg.sv
module softint_reg
  import softint_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SOFT_W = 32,
  parameter int N_TMR  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  sop_e              op_kind,
  input  logic              op_priv,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [N_TMR-1:0]  tmr_hits,
  output logic [SOFT_W-1:0] soft_q,
  output logic [DATA_W-1:0] rd_data,
  output logic              illegal
);

  localparam int PAD_W = DATA_W - SOFT_W;

  function automatic logic [SOFT_W-1:0] apply_op(
    input logic [SOFT_W-1:0] cur, input sop_e k, input logic [SOFT_W-1:0] v);
    case (k)
      OP_SET:   return cur | v;
      OP_CLR:   return cur & ~v;
      OP_WRITE: return v;
      default:  return cur;
    endcase
  endfunction

  logic              accept;
  logic              wr_en;
  logic              tmr_any;
  logic [SOFT_W-1:0] operand;
  logic [SOFT_W-1:0] soft_d;
  logic              unused_hi;

  assign accept    = op_valid && op_priv;
  assign illegal   = op_valid && !op_priv;
  assign wr_en     = accept && (op_kind != OP_READ);
  assign tmr_any   = |tmr_hits;
  assign operand   = src_a[SOFT_W-1:0] ^ src_b[SOFT_W-1:0];
  assign unused_hi = ^{src_a[DATA_W-1:SOFT_W], src_b[DATA_W-1:SOFT_W]};

  always_comb begin
    soft_d = wr_en ? apply_op(soft_q, op_kind, operand) : soft_q;
    if (tmr_any) soft_d[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) soft_q <= '0;
    else        soft_q <= soft_d;
  end

  assign rd_data = (accept && op_kind == OP_READ) ? {{PAD_W{1'b0}}, soft_q} : '0;

  p_refused_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal && !tmr_any) |=> (soft_q == $past(soft_q)));

  p_timer_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_any |=> soft_q[0]);

  p_write_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_kind == OP_WRITE && !tmr_any) |=>
      (soft_q == ($past(src_a[SOFT_W-1:0]) ^ $past(src_b[SOFT_W-1:0]))));

endmodule

// File: rtl/level_sync.sv
module level_sync #(
  parameter int LEVELS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] lvl_in,
  input  logic              sleep_req,
  output logic [LEVELS-1:0] lvl_q,
  output logic              halted,
  output logic              wake
);

  assign wake = |(lvl_in & ~lvl_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      halted <= 1'b0;
    end else begin
      lvl_q <= lvl_in;
      if (wake)           halted <= 1'b0;
      else if (sleep_req) halted <= 1'b1;
    end
  end

  p_wake_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> !halted);

  p_sleep_sets_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && !wake) |=> halted);

endmodule

// File: rtl/level_prio.sv
module level_prio #(
  parameter int LEVELS    = 16,
  parameter int SOFT_W    = 32,
  parameter int TIMER_LVL = 14,
  parameter int LVL_W     = $clog2(LEVELS)
) (
  input  logic [LEVELS-1:0] lvl_q,
  input  logic [SOFT_W-1:0] soft_q,
  output logic [LEVELS-1:0] req_vec,
  output logic              any_req,
  output logic              hit,
  output logic [LVL_W-1:0]  lvl_sel
);

  function automatic logic [LVL_W:0] top_level(input logic [LEVELS-1:0] v);
    logic [LVL_W:0] r;
    r = '0;
    for (int i = 1; i < LEVELS; i++)
      if (v[i]) r = {1'b1, LVL_W'(i)};
    return r;
  endfunction

  for (genvar g = 0; g < LEVELS; g++) begin : g_req
    logic soft_bit;
    logic tmr_bit;
    if (g == 0) begin : g_zero
      assign soft_bit = 1'b0;
    end else begin : g_plain
      assign soft_bit = soft_q[g];
    end
    if (g == TIMER_LVL) begin : g_tmr
      assign tmr_bit = soft_q[0];
    end else begin : g_notmr
      assign tmr_bit = 1'b0;
    end
    assign req_vec[g] = lvl_q[g] | soft_bit | tmr_bit;
  end

  logic unused_soft;
  assign unused_soft = ^soft_q[SOFT_W-1:LEVELS];

  assign any_req        = |req_vec;
  assign {hit, lvl_sel} = top_level(req_vec);

endmodule

// File: rtl/pend_ctrl.sv
module pend_ctrl #(
  parameter int          TT_W   = 9,
  parameter int          LVL_W  = 4,
  parameter logic [TT_W-1:0] TT_EXT = 9'h040
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            any_req,
  input  logic            hit,
  input  logic [LVL_W-1:0] lvl_sel,
  input  logic            trap_load,
  input  logic [TT_W-1:0] trap_code,
  output logic [TT_W-1:0] code_q,
  output logic            irq_set,
  output logic            irq_drop
);

  function automatic logic is_ext(input logic [TT_W-1:0] c);
    return c[TT_W-1:LVL_W] == TT_EXT[TT_W-1:LVL_W];
  endfunction

  function automatic logic [TT_W-1:0] make_code(input logic [LVL_W-1:0] l);
    return {TT_EXT[TT_W-1:LVL_W], l};
  endfunction

  logic            open_slot;
  logic            do_take;
  logic            do_clear;
  logic [TT_W-1:0] new_code;

  assign open_slot = (code_q == '0) || is_ext(code_q);
  assign new_code  = make_code(lvl_sel);
  assign do_take   = !trap_load && any_req && open_slot && hit && (new_code != code_q);
  assign do_clear  = !trap_load && !any_req && is_ext(code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q   <= '0;
      irq_set  <= 1'b0;
      irq_drop <= 1'b0;
    end else begin
      irq_set  <= do_take;
      irq_drop <= do_clear;
      if (trap_load)     code_q <= trap_code;
      else if (do_take)  code_q <= new_code;
      else if (do_clear) code_q <= '0;
    end
  end

  p_set_changes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> (is_ext(code_q) && code_q != $past(code_q)));

  p_drop_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_drop |-> (code_q == '0));

  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_set && irq_drop));

  p_foreign_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_load && code_q != '0 && !is_ext(code_q)) |=> (code_q == $past(code_q)));

endmodule

// File: rtl/softint_level_arbiter.sv
module softint_level_arbiter
  import softint_pkg::*;
#(
  parameter int              DATA_W    = 64,
  parameter int              SOFT_W    = 32,
  parameter int              LEVELS    = 16,
  parameter int              TIMER_LVL = 14,
  parameter int              TT_W      = 9,
  parameter logic [TT_W-1:0] TT_EXT    = 9'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              op_priv,
  input  logic [DATA_W-1:0] op_src_a,
  input  logic [DATA_W-1:0] op_src_b,
  output logic [DATA_W-1:0] rd_data,
  output logic              op_illegal,
  input  logic [LEVELS-1:0] lvl_in,
  input  logic              tick_hit,
  input  logic              stick_hit,
  input  logic              htick_hit,
  input  logic              sleep_req,
  input  logic              trap_load,
  input  logic [TT_W-1:0]   trap_code,
  output logic [TT_W-1:0]   pend_code,
  output logic              irq_set,
  output logic              irq_drop,
  output logic              halted
);

  localparam int LVL_W = $clog2(LEVELS);
  localparam int N_TMR = 3;

  logic [SOFT_W-1:0] soft_q;
  logic [LEVELS-1:0] lvl_q;
  logic [LEVELS-1:0] req_vec;
  logic              any_req;
  logic              hit;
  logic [LVL_W-1:0]  lvl_sel;
  logic              wake;

  softint_reg #(.DATA_W(DATA_W), .SOFT_W(SOFT_W), .N_TMR(N_TMR)) u_reg (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(sop_e'(op_kind)),
    .op_priv(op_priv), .src_a(op_src_a), .src_b(op_src_b),
    .tmr_hits({htick_hit, stick_hit, tick_hit}),
    .soft_q(soft_q), .rd_data(rd_data), .illegal(op_illegal)
  );

  level_sync #(.LEVELS(LEVELS)) u_sync (
    .clk(clk), .rst_n(rst_n), .lvl_in(lvl_in), .sleep_req(sleep_req),
    .lvl_q(lvl_q), .halted(halted), .wake(wake)
  );

  level_prio #(.LEVELS(LEVELS), .SOFT_W(SOFT_W), .TIMER_LVL(TIMER_LVL),
               .LVL_W(LVL_W)) u_prio (
    .lvl_q(lvl_q), .soft_q(soft_q), .req_vec(req_vec), .any_req(any_req),
    .hit(hit), .lvl_sel(lvl_sel)
  );

  pend_ctrl #(.TT_W(TT_W), .LVL_W(LVL_W), .TT_EXT(TT_EXT)) u_pend (
    .clk(clk), .rst_n(rst_n), .any_req(any_req), .hit(hit), .lvl_sel(lvl_sel),
    .trap_load(trap_load), .trap_code(trap_code), .code_q(pend_code),
    .irq_set(irq_set), .irq_drop(irq_drop)
  );

  p_level0_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_load && req_vec == LEVELS'(1) && pend_code == '0) |=> (pend_code == '0));

endmodule

// File: tb/softint_level_arbiter_tb.sv
module softint_level_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'd0;
  logic        op_priv = 1'b0;
  logic [63:0] op_src_a = '0;
  logic [63:0] op_src_b = '0;
  logic [63:0] rd_data;
  logic        op_illegal;
  logic [15:0] lvl_in = '0;
  logic        tick_hit = 1'b0, stick_hit = 1'b0, htick_hit = 1'b0;
  logic        sleep_req = 1'b0;
  logic        trap_load = 1'b0;
  logic [8:0]  trap_code = '0;
  logic [8:0]  pend_code;
  logic        irq_set, irq_drop, halted;

  softint_level_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_priv(op_priv), .op_src_a(op_src_a), .op_src_b(op_src_b),
    .rd_data(rd_data), .op_illegal(op_illegal), .lvl_in(lvl_in),
    .tick_hit(tick_hit), .stick_hit(stick_hit), .htick_hit(htick_hit),
    .sleep_req(sleep_req), .trap_load(trap_load), .trap_code(trap_code),
    .pend_code(pend_code), .irq_set(irq_set), .irq_drop(irq_drop),
    .halted(halted)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_run = 0, n_fail = 0;
  string cur_tag = "";
  bit    finished = 1'b0;

  logic [31:0] soft_m;
  logic [15:0] lvl_m;
  logic [8:0]  code_m;
  logic        halted_m, set_m, drop_m;

  function automatic string tg(string d);
    return (cur_tag != "") ? cur_tag : d;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_req(logic [15:0] l, logic [31:0] s);
    logic [15:0] r;
    r = l;
    for (int b = 1; b < 16; b++) if (s[b]) r[b] = 1'b1;
    if (s[0]) r[14] = 1'b1;
    return r;
  endfunction

  function automatic int ref_top(logic [15:0] r);
    for (int b = 15; b >= 1; b--) if (r[b]) return b;
    return 0;
  endfunction

  function automatic bit ref_ext(logic [8:0] c);
    return (c >> 4) == 5'h04;
  endfunction

  task automatic step(bit v, logic [1:0] k, bit p, logic [63:0] a, logic [63:0] b,
                      logic [15:0] l, logic [2:0] t, bit slp, bit tl, logic [8:0] tc);
    logic [31:0] x, s_n;
    logic [15:0] r;
    logic [8:0]  c_n;
    int          top;
    bit          wk;
    @(negedge clk);
    op_valid = v; op_kind = k; op_priv = p; op_src_a = a; op_src_b = b;
    lvl_in = l; {htick_hit, stick_hit, tick_hit} = t; sleep_req = slp;
    trap_load = tl; trap_code = tc;
    #1;
    chk(tg("R4"), {63'd0, op_illegal}, {63'd0, v && !p});
    chk(tg("R5"), rd_data, (v && p && k == 2'd0) ? {32'd0, soft_m} : 64'd0);
    x = a[31:0] ^ b[31:0];
    s_n = soft_m;
    if (v && p) begin
      if (k == 2'd1) s_n = soft_m | x;
      if (k == 2'd2) s_n = soft_m & ~x;
      if (k == 2'd3) s_n = x;
    end
    if (t != 3'd0) s_n[0] = 1'b1;
    r = ref_req(lvl_m, soft_m);
    top = ref_top(r);
    c_n = code_m; set_m = 1'b0; drop_m = 1'b0;
    if (tl) c_n = tc;
    else if (r != 16'd0) begin
      if ((code_m == 9'd0 || ref_ext(code_m)) && top != 0 &&
          (9'h040 | 9'(top)) != code_m) begin
        c_n = 9'h040 | 9'(top); set_m = 1'b1;
      end
    end else if (ref_ext(code_m)) begin
      c_n = 9'd0; drop_m = 1'b1;
    end
    wk = (l & ~lvl_m) != 16'd0;
    if (wk) halted_m = 1'b0; else if (slp) halted_m = 1'b1;
    soft_m = s_n; lvl_m = l; code_m = c_n;
    @(posedge clk); #1;
    chk(tg("R8"),  {55'd0, pend_code}, {55'd0, code_m});
    chk(tg("R9"),  {63'd0, irq_set},   {63'd0, set_m});
    chk(tg("R10"), {63'd0, irq_drop},  {63'd0, drop_m});
    chk(tg("R12"), {63'd0, halted},    {63'd0, halted_m});
  endtask

  task automatic op(logic [1:0] k, logic [63:0] a, logic [63:0] b);
    step(1, k, 1, a, b, lvl_m, 3'd0, 0, 0, 9'd0);
  endtask

  task automatic idle(logic [15:0] l);
    step(0, 2'd0, 0, '0, '0, l, 3'd0, 0, 0, 9'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    soft_m = '0; lvl_m = '0; code_m = '0; halted_m = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    cur_tag = "R13";
    chk("R13", {55'd0, pend_code}, 64'd0);
    chk("R13", {62'd0, irq_set, irq_drop}, 64'd0);
    chk("R13", {63'd0, halted}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    op(2'd0, '0, '0);
    cur_tag = "R3";
    op(2'd3, 64'hFFFF_0000_A5A5_00FF, 64'h1234_0000_0000_F0F0);
    op(2'd0, '0, '0);
    cur_tag = "R1";
    op(2'd1, 64'h0000_0000_0F00_0000, 64'h0000_0000_0000_0000);
    op(2'd0, '0, '0);
    cur_tag = "R2";
    op(2'd2, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0F0F_0000);
    op(2'd0, '0, '0);
    op(2'd3, 64'd0, 64'd0);
    cur_tag = "R4";
    step(1, 2'd3, 0, 64'hFFFF, 64'd0, 16'd0, 3'd0, 0, 0, 9'd0);
    step(1, 2'd0, 0, 64'd0, 64'd0, 16'd0, 3'd0, 0, 0, 9'd0);
    op(2'd0, '0, '0);
    cur_tag = "R6";
    step(1, 2'd2, 1, 64'hFFFF_FFFF, 64'd0, 16'd0, 3'b010, 0, 0, 9'd0);
    op(2'd0, '0, '0);
    cur_tag = "R7";
    idle(16'd0);
    op(2'd3, 64'd0, 64'd0);
    idle(16'd0); idle(16'd0);
    idle(16'h0001); idle(16'h0001);
    idle(16'h8001); idle(16'h8001);
    cur_tag = "R9";
    idle(16'h0004); idle(16'h0024); idle(16'h0024); idle(16'h0424);
    cur_tag = "R10";
    idle(16'd0); idle(16'd0); idle(16'd0);
    cur_tag = "R11";
    step(0, 2'd0, 0, '0, '0, 16'd0, 3'd0, 0, 1, 9'h010);
    idle(16'h0800); idle(16'h0800); idle(16'd0); idle(16'd0);
    step(0, 2'd0, 0, '0, '0, 16'd0, 3'd0, 0, 1, 9'h000);
    idle(16'h0800); idle(16'h0800);
    cur_tag = "R12";
    step(0, 2'd0, 0, '0, '0, 16'h0800, 3'd0, 1, 0, 9'd0);
    idle(16'h0800);
    step(0, 2'd0, 0, '0, '0, 16'h0000, 3'd0, 1, 0, 9'd0);
    step(0, 2'd0, 0, '0, '0, 16'h0002, 3'd0, 1, 0, 9'd0);
    cur_tag = "";
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] l;
      logic [8:0]  tc;
      l = lvl_m;
      if ($urandom_range(3) == 0) l = 16'(1) << $urandom_range(15);
      if ($urandom_range(5) == 0) l = 16'd0;
      if ($urandom_range(7) == 0) l = l | (16'(1) << $urandom_range(15));
      case ($urandom_range(3))
        0: tc = 9'h000;
        1: tc = 9'h040 | 9'($urandom_range(15));
        2: tc = 9'h010 + 9'($urandom_range(15));
        default: tc = 9'($urandom);
      endcase
      step($urandom_range(2) != 0, 2'($urandom), $urandom_range(4) != 0,
           {$urandom, $urandom} & {32'hFFFF_FFFF, 32'h0000_FFFF},
           {$urandom, $urandom} & {32'hFFFF_FFFF, 32'h0000_C0FF},
           l, ($urandom_range(9) == 0) ? 3'(1 << $urandom_range(2)) : 3'd0,
           $urandom_range(9) == 0, $urandom_range(24) == 0, tc);
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule